// File: doc/BRIEF.md
# Phase-Encoded Read Group Transfer Sequencer

This block paces the movement of phase-encoded read data, five bytes at a time, out of the per-track skew buffers. It waits until every track reports that it holds a full group. It then issues one load pulse and four shift pulses on back-to-back cycles, and captures the byte presented on each of those cycles into a local holding buffer. When the group is captured, a correction-busy flag goes high. This flag stops any further transfer from the skew buffers until the current group has left.

No separate correction cycle exists. In the same cycle that the busy flag rises, the block starts writing the held bytes to a downstream buffer in their capture order. Each byte is XORed with a correction mask that the external error-correction logic supplies for the byte index the block shows. When the downstream buffer reports full, the write stalls and resumes when the buffer reports empty. After the last byte is written, the busy flag drops and the next group may be loaded.

Top module: `pe_group_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the correction-busy flag (`ecc_full`), the byte counter and the shift-out state. While it is asserted, and in the cycle after it is released, `load_pulse`, `shift_pulse` and `out_valid` are low.
- R2: A transfer starts only after a cycle in which all TRACKS bits of `trk_rdy` are high together. `load_pulse` is asserted in the following cycle. A vector with any bit low never starts a transfer.
- R3: A transfer is exactly one `load_pulse` cycle followed directly by four `shift_pulse` cycles. The value on `skew_byte` in each of these five cycles is captured as byte 0 to byte 4 of the group.
- R4: `ecc_full` goes high in the cycle after the fourth shift pulse. While it is high, no load or shift pulse appears, whatever `trk_rdy` shows.
- R5: Shift-out starts in the same cycle that `ecc_full` rises. If `dn_full` is low in that cycle, `out_valid` is high.
- R6: In each write cycle, `out_byte` equals the held byte at index `fix_sel` XOR `fix_mask`. `fix_sel` steps 0,1,2,3,4, so bytes leave in the order they were captured.
- R7: While `dn_full` is high, `out_valid` is low and `fix_sel` holds its value. Writing resumes at the same index once `dn_full` is low.
- R8: `ecc_full` clears in the cycle after the fifth write, and the next group can then be loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trk_rdy | input | 9 | One ready flag per track |
| skew_byte | input | 9 | Byte from the skew buffers during load/shift cycles |
| fix_mask | input | 9 | XOR correction for the byte at `fix_sel` |
| dn_full | input | 1 | Downstream buffer full; stalls shift-out |
| load_pulse | output | 1 | Load-group pulse (first byte of a group) |
| shift_pulse | output | 1 | Shift-group pulse (bytes 1 to 4) |
| ecc_full | output | 1 | Correction stage busy; blocks new transfers |
| fix_sel | output | 3 | Index of the held byte being written |
| out_valid | output | 1 | Write strobe to the downstream buffer |
| out_byte | output | 9 | Corrected byte |

## Verification
The hardest case to produce is a stall that lands on the very first shift-out cycle, where `ecc_full` has just risen and no byte has been written yet. A stall in the middle of a group combined with the track-ready flags held high throughout is similarly hard. The vector table holds a stall pattern per group and drives `dn_full` from it cycle by cycle from the moment capture ends. One entry stalls on its first cycle and another stalls in bursts. Because `trk_rdy` stays asserted for the whole shift-out, any transfer that leaks through the busy flag would show up as a stray pulse.

// File: rtl/pe_group_pkg.sv
package pe_group_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GRAB  = 2'd1,
      ST_DRAIN = 2'd2
   } grp_state_e;
endpackage

// File: rtl/pe_group_ctrl.sv
module pe_group_ctrl
   import pe_group_pkg::*;
#(
   parameter int TRACKS = 9,
   parameter int GROUP  = 5,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TRACKS-1:0] trk_rdy,
   input  logic              dn_full,
   output logic              load_pulse,
   output logic              shift_pulse,
   output logic              cap_en,
   output logic              wr_en,
   output logic [CNT_W-1:0]  idx,
   output logic              ecc_full
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);

   grp_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             all_rdy;

   assign all_rdy = &trk_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         ecc_full <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (all_rdy) state <= ST_GRAB;
            end
            ST_GRAB: begin
               if (cnt == LAST) begin
                  state    <= ST_DRAIN;
                  cnt      <= '0;
                  ecc_full <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (!dn_full) begin
                  if (cnt == LAST) begin
                     state    <= ST_IDLE;
                     cnt      <= '0;
                     ecc_full <= 1'b0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cap_en      = (state == ST_GRAB);
      load_pulse  = cap_en && (cnt == '0);
      shift_pulse = cap_en && (cnt != '0);
      wr_en       = (state == ST_DRAIN) && !dn_full;
      idx         = cnt;
   end
endmodule

// File: rtl/pe_group_hold.sv
module pe_group_hold #(
   parameter int GROUP   = 5,
   parameter int BYTE_W  = 9,
   parameter int CNT_W   = 3,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              cap_en,
   input  logic [CNT_W-1:0]  idx,
   input  logic [BYTE_W-1:0] din,
   input  logic [BYTE_W-1:0] mask,
   output logic [BYTE_W-1:0] dout
);
   logic [BYTE_W-1:0] ent [GROUP];
   logic [BYTE_W-1:0] raw;

   always_ff @(posedge clk) begin
      for (int g = 0; g < GROUP; g++) begin
         if (cap_en && (idx == CNT_W'(g))) ent[g] <= din;
      end
   end

   always_comb begin
      raw = '0;
      for (int g = 0; g < GROUP; g++) begin
         if (idx == CNT_W'(g)) raw = ent[g];
      end
   end

   generate
      if (MASK_EN) begin : g_fix
         assign dout = raw ^ mask;
      end else begin : g_pass
         logic [BYTE_W-1:0] unused_mask;
         assign unused_mask = mask;
         assign dout = raw;
      end
   endgenerate
endmodule

// File: rtl/pe_group_sequencer.sv
module pe_group_sequencer #(
   parameter int TRACKS  = 9,
   parameter int BYTE_W  = 9,
   parameter int GROUP   = 5,
   parameter bit MASK_EN = 1'b1,
   localparam int CNT_W  = (GROUP > 1) ? $clog2(GROUP) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TRACKS-1:0] trk_rdy,
   input  logic [BYTE_W-1:0] skew_byte,
   input  logic [BYTE_W-1:0] fix_mask,
   input  logic              dn_full,
   output logic              load_pulse,
   output logic              shift_pulse,
   output logic              ecc_full,
   output logic [CNT_W-1:0]  fix_sel,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte
);
   generate
      if (GROUP < 2) begin : g_bad_group
         $error("GROUP must be at least 2");
      end
      if (TRACKS < 1) begin : g_bad_tracks
         $error("TRACKS must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_width
         $error("BYTE_W must be at least 1");
      end
   endgenerate

   logic             cap_en;
   logic             wr_en;
   logic [CNT_W-1:0] idx;

   pe_group_ctrl #(
      .TRACKS (TRACKS),
      .GROUP  (GROUP),
      .CNT_W  (CNT_W)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .trk_rdy     (trk_rdy),
      .dn_full     (dn_full),
      .load_pulse  (load_pulse),
      .shift_pulse (shift_pulse),
      .cap_en      (cap_en),
      .wr_en       (wr_en),
      .idx         (idx),
      .ecc_full    (ecc_full)
   );

   pe_group_hold #(
      .GROUP   (GROUP),
      .BYTE_W  (BYTE_W),
      .CNT_W   (CNT_W),
      .MASK_EN (MASK_EN)
   ) u_hold (
      .clk    (clk),
      .cap_en (cap_en),
      .idx    (idx),
      .din    (skew_byte),
      .mask   (fix_mask),
      .dout   (out_byte)
   );

   assign out_valid = wr_en;
   assign fix_sel   = idx;
endmodule

// File: rtl/pe_group_sequencer_chk.sv
module pe_group_sequencer_chk #(
   parameter int TRACKS = 9,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [TRACKS-1:0] trk_rdy,
   input logic              dn_full,
   input logic              load_pulse,
   input logic              shift_pulse,
   input logic              ecc_full,
   input logic [CNT_W-1:0]  fix_sel,
   input logic              out_valid
);
   logic [2:0] shifts;

   always_ff @(posedge clk) begin
      if (rst || load_pulse) shifts <= '0;
      else if (shift_pulse)  shifts <= shifts + 1'b1;
   end

   AST_LOAD_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
      load_pulse |-> $past(&trk_rdy)); // R2
   AST_SHIFT_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
      load_pulse |=> shift_pulse); // R3
   AST_FOUR_SHIFTS: assert property (@(posedge clk) disable iff (rst)
      shift_pulse |-> (shifts < 3'd4)); // R3
   AST_BUSY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (shift_pulse && shifts == 3'd3) |=> ecc_full); // R4
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      ecc_full |-> !(load_pulse || shift_pulse)); // R4
   AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ecc_full); // R6
   AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      dn_full |-> !out_valid); // R7
   AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
      (ecc_full && dn_full) |=> $stable(fix_sel)); // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
      $onehot0({load_pulse, shift_pulse, out_valid})); // R3
endmodule

bind pe_group_sequencer pe_group_sequencer_chk #(
   .TRACKS (TRACKS),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .trk_rdy     (trk_rdy),
   .dn_full     (dn_full),
   .load_pulse  (load_pulse),
   .shift_pulse (shift_pulse),
   .ecc_full    (ecc_full),
   .fix_sel     (fix_sel),
   .out_valid   (out_valid)
);

// File: tb/pe_group_sequencer_tb.sv
`timescale 1ns/1ps
module pe_group_sequencer_tb;
   localparam int NV = 4;
   localparam logic [44:0] V_DATA [NV] = '{
      {9'h010, 9'h0FF, 9'h1AA, 9'h055, 9'h1FF},
      {9'h123, 9'h045, 9'h167, 9'h089, 9'h1AB},
      {9'h000, 9'h000, 9'h000, 9'h000, 9'h1FF},
      {9'h101, 9'h0F0, 9'h00F, 9'h1E1, 9'h03C}};
   localparam logic [44:0] V_MASK [NV] = '{
      {9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
      {9'h001, 9'h100, 9'h0FF, 9'h000, 9'h1FF},
      {9'h003, 9'h000, 9'h080, 9'h000, 9'h001},
      {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF}};
   localparam logic [7:0] V_STALL [NV] = '{8'h00, 8'h01, 8'h16, 8'h33};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] trk_rdy = '0;
   logic [8:0] skew_byte = '0;
   logic [8:0] fix_mask = '0;
   logic       dn_full = 1'b0;
   logic       load_pulse, shift_pulse, ecc_full, out_valid;
   logic [2:0] fix_sel;
   logic [8:0] out_byte;
   int         n_run = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   pe_group_sequencer u_dut (
      .clk(clk), .rst(rst), .trk_rdy(trk_rdy), .skew_byte(skew_byte),
      .fix_mask(fix_mask), .dn_full(dn_full), .load_pulse(load_pulse),
      .shift_pulse(shift_pulse), .ecc_full(ecc_full), .fix_sel(fix_sel),
      .out_valid(out_valid), .out_byte(out_byte));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_group(input logic [44:0] d, input logic [44:0] m, input logic [7:0] st);
      int wait_c = 0;
      int n = 0;
      int c = 0;
      trk_rdy = '1;
      @(negedge clk);
      while (!load_pulse && wait_c < 5) begin
         @(negedge clk);
         wait_c++;
      end
      chk("R2 load after all ready", 32'(load_pulse), 1);
      for (int i = 0; i < 5; i++) begin
         chk("R3 load pulse position", 32'(load_pulse), (i == 0) ? 1 : 0);
         chk("R3 shift pulse position", 32'(shift_pulse), (i == 0) ? 0 : 1);
         skew_byte = d[i*9 +: 9];
         @(negedge clk);
      end
      chk("R4 ecc_full after fourth shift", 32'(ecc_full), 1);
      while (n < 5 && c < 40) begin
         dn_full = st[c % 8];
         fix_mask = m[int'(fix_sel)*9 +: 9];
         #1;
         chk("R4 no pulse while busy", 32'(load_pulse | shift_pulse), 0);
         if (dn_full) begin
            chk("R7 no write while full", 32'(out_valid), 0);
         end else begin
            if (c == 0) chk("R5 write in first busy cycle", 32'(out_valid), 1);
            chk("R6 write strobe", 32'(out_valid), 1);
            chk("R6 byte index order", 32'(fix_sel), 32'(n));
            chk("R6 corrected byte", 32'(out_byte), 32'(d[n*9 +: 9] ^ m[n*9 +: 9]));
            n++;
         end
         @(negedge clk);
         c++;
      end
      dn_full = 1'b0;
      trk_rdy = '0;
      chk("R8 ecc_full cleared after fifth write", 32'(ecc_full), 0);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ecc_full in reset", 32'(ecc_full), 0);
      chk("R1 strobes in reset", 32'({load_pulse, shift_pulse, out_valid}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle after reset", 32'({load_pulse, shift_pulse, out_valid, ecc_full}), 0);

      for (int v = 0; v < NV; v++) begin
         run_group(V_DATA[v], V_MASK[v], V_STALL[v]);
         @(negedge clk);
      end

      // R2: staggered and partial readiness never start a transfer
      for (int t = 0; t < 9; t++) begin
         trk_rdy = 9'h1FF & ~(9'h1 << t);
         @(negedge clk);
         chk("R2 partial ready no load", 32'(load_pulse | shift_pulse), 0);
      end
      trk_rdy = '0;
      @(negedge clk);

      // R8: back-to-back groups with ready held high
      run_group(V_DATA[1], V_MASK[0], 8'h00);
      run_group(V_DATA[3], V_MASK[2], 8'h00);
      @(negedge clk);

      // R1: reset in the middle of shift-out
      trk_rdy = '1;
      dn_full = 1'b1;
      repeat (8) @(negedge clk);
      chk("R7 stalled group still busy", 32'(ecc_full), 1);
      trk_rdy = '0;
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset clears busy", 32'(ecc_full), 0);
      chk("R1 reset clears write", 32'(out_valid), 0);
      chk("R1 reset clears index", 32'(fix_sel), 0);
      rst = 1'b0;
      dn_full = 1'b0;
      @(negedge clk);
      chk("R1 no activity after reset", 32'({load_pulse, shift_pulse, out_valid}), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule